// File: doc/BRIEF.md
# IPv4 Forwarding Header Checker

This block sits in a line card's fast path and inspects an IPv4 header as it streams past, one 32-bit word per clock and without stalling. A start marker flags the first word of each header. The block also samples two per-packet inputs with that first word: the MTU of the outgoing link and a flag that marks the packet for local delivery. While the words flow through, it checks the version nibble, the header-length nibble and the header checksum. For a packet that will leave through an output port, it decrements the time-to-live byte and patches the checksum in place. Every word leaves one cycle after it arrives.

One cycle after the last header word, the block gives a verdict: a discard flag, a reason code and a fragmentation-needed flag. The fragmentation flag is raised when the total length of a forwarded packet exceeds the MTU. Words that follow the header pass through untouched until the next start marker. Route lookup, options, the fragmentation itself and the payload are left to other blocks.

Top module: `ipv4_fwd_checker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid, verdict_valid, discard and frag_needed are 0.
- R2: Every input word with in_valid=1 appears on out_data with out_valid=1 exactly one clock later, with no stall. Words after the header's last word are passed unmodified.
- R3: If the version nibble (word 0 bits 31:28) is not 4, the verdict is a discard with reason 1.
- R4: If the header-length nibble (word 0 bits 27:24, in 32-bit words) is below 5, the verdict is a discard with reason 2. The header is then taken to be 5 words long.
- R5: The 16-bit halves of all header words are summed in ones-complement arithmetic (end-around carry). Any sum other than 0xFFFF gives a discard with reason 3.
- R6: A packet with local_dst=1 at its start word has no word modified. It is discarded with reason 4 only when its TTL (word 2 bits 31:24) is 0.
- R7: For a packet with local_dst=0, output word 2 carries TTL-1 in bits 31:24. Its bits 15:0 carry the stored checksum ones-complement-added to 0x0100 with end-around carry. Bits 23:16 are unchanged.
- R8: A packet with local_dst=0 whose TTL is 0 or 1 (so that the decremented TTL is not positive) is discarded with reason 4.
- R9: When several faults are present, the lowest reason code wins: version (1) before length (2) before checksum (3) before TTL (4).
- R10: verdict_valid is a single-cycle pulse, in the cycle after the last header word was accepted. In that cycle discard is 1 exactly when the reason is nonzero, and reason 0 means accept.
- R11: frag_needed is 1 in the verdict cycle when local_dst=0 and the total length (word 0 bits 15:0) is strictly greater than the mtu sampled with the start word. This holds whether or not the packet is discarded. It is always 0 for local packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Input word is header word 0 |
| in_data | input | 32 | Header or trailing word |
| mtu | input | 16 | Outgoing link MTU, sampled with the start word |
| local_dst | input | 1 | Packet is for local delivery, sampled with the start word |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Word after TTL and checksum rewrite |
| verdict_valid | output | 1 | Verdict fields are valid this cycle |
| discard | output | 1 | Packet must be dropped |
| drop_reason | output | 3 | 0 accept, 1 version, 2 length, 3 checksum, 4 TTL |
| frag_needed | output | 1 | Forwarded packet is longer than the MTU |

## Verification
Two conditions can land in the same verdict cycle: a TTL-expiry discard and the oversize fragmentation flag. Both are judged from a single sample of the verdict outputs. The bench provokes this directly with a forwarded packet whose TTL is 1 and whose total length is one above the MTU, and it also reaches the overlap in random traffic, since TTL and MTU are chosen near their limits. In a given verdict the bench expects reason 4 together with frag_needed=1, while the rewritten word 2 still carries the decremented TTL and the patched checksum.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int TTL_W  = 8;
  localparam int IDX_W  = 4;
  localparam int RSN_W  = 3;
  localparam logic [3:0] IPV4_VERSION = 4'd4;
  localparam logic [IDX_W-1:0] MIN_HDR_WORDS = 4'd5;
  localparam logic [IDX_W-1:0] TTL_WORD_IDX = 4'd2;
  localparam logic [HALF_W-1:0] TTL_CKS_STEP = 16'h0100;
  localparam logic [HALF_W-1:0] CKS_GOOD = 16'hFFFF;

  typedef enum logic [RSN_W-1:0] {
    RSN_NONE     = 3'd0,
    RSN_VERSION  = 3'd1,
    RSN_HDRLEN   = 3'd2,
    RSN_CHECKSUM = 3'd3,
    RSN_TTL      = 3'd4
  } drop_rsn_e;

  // ones-complement 16-bit addition with end-around carry
  function automatic logic [HALF_W-1:0] oc_add(input logic [HALF_W-1:0] a,
                                               input logic [HALF_W-1:0] b);
    logic [HALF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, s[HALF_W]};
  endfunction

  // fold both halves of a header word into a running sum
  function automatic logic [HALF_W-1:0] csum_word(input logic [HALF_W-1:0] acc,
                                                  input logic [WORD_W-1:0] w);
    return oc_add(oc_add(acc, w[WORD_W-1:HALF_W]), w[HALF_W-1:0]);
  endfunction
endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker
  import ipv4_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sop,
  input  logic [3:0]       ihl_field,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_in_hdr,
  output logic             cur_last
);
  logic [IDX_W-1:0] cnt_q, len_q, eff_len, cur_len;
  logic             active_q;

  assign eff_len    = (ihl_field < MIN_HDR_WORDS) ? MIN_HDR_WORDS : ihl_field;
  assign cur_len    = sop ? eff_len : len_q;
  assign cur_idx    = sop ? '0 : cnt_q;
  assign cur_in_hdr = sop | active_q;
  assign cur_last   = cur_in_hdr && (cur_idx == cur_len - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      len_q    <= MIN_HDR_WORDS;
      active_q <= 1'b0;
    end else if (in_valid && cur_in_hdr) begin
      cnt_q    <= cur_idx + 4'd1;
      len_q    <= cur_len;
      active_q <= !cur_last;
    end
  end
endmodule

// File: rtl/hdr_csum_acc.sv
module hdr_csum_acc
  import ipv4_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_en,
  input  logic              restart,
  input  logic [WORD_W-1:0] word,
  output logic [HALF_W-1:0] sum_next
);
  logic [HALF_W-1:0] acc_q, base;

  assign base     = restart ? '0 : acc_q;
  assign sum_next = csum_word(base, word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (word_en) acc_q <= sum_next;
  end
endmodule

// File: rtl/hdr_word_rewrite.sv
module hdr_word_rewrite
  import ipv4_hdr_pkg::*;
(
  input  logic              is_ttl_word,
  input  logic              forward,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);
  logic [TTL_W-1:0]  ttl_dec;
  logic [HALF_W-1:0] cks_new;

  assign ttl_dec = word_in[WORD_W-1 -: TTL_W] - 8'd1;
  assign cks_new = oc_add(word_in[HALF_W-1:0], TTL_CKS_STEP);

  always_comb begin
    word_out = word_in;
    if (forward && is_ttl_word)
      word_out = {ttl_dec, word_in[HALF_W+TTL_W-1:HALF_W], cks_new};
  end
endmodule

// File: rtl/ipv4_fwd_checker.sv
module ipv4_fwd_checker
  import ipv4_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [31:0] in_data,
  input  logic [15:0] mtu,
  input  logic        local_dst,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        verdict_valid,
  output logic        discard,
  output logic [2:0]  drop_reason,
  output logic        frag_needed
);
  logic             sop, cur_in_hdr, cur_last, cur_local, is_ttl_word;
  logic             hdr_fire, verdict_fire, pass_word, ttl_fail;
  logic [IDX_W-1:0] cur_idx;
  logic [HALF_W-1:0] sum_next;
  logic [WORD_W-1:0] word_new;
  logic             local_q, ver_bad_q, len_bad_q, over_q;
  logic [TTL_W-1:0] ttl_q;
  drop_rsn_e        rsn_next;

  assign sop          = in_valid & in_sop;
  assign cur_local    = sop ? local_dst : local_q;
  assign is_ttl_word  = cur_in_hdr && (cur_idx == TTL_WORD_IDX);
  assign hdr_fire     = in_valid && cur_in_hdr;
  assign verdict_fire = hdr_fire && cur_last;
  assign pass_word    = in_valid && !cur_in_hdr;

  hdr_word_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sop(sop),
    .ihl_field(in_data[27:24]), .cur_idx(cur_idx),
    .cur_in_hdr(cur_in_hdr), .cur_last(cur_last)
  );

  hdr_csum_acc u_sum (
    .clk(clk), .rst_n(rst_n), .word_en(hdr_fire), .restart(sop),
    .word(in_data), .sum_next(sum_next)
  );

  hdr_word_rewrite u_rw (
    .is_ttl_word(is_ttl_word), .forward(!cur_local),
    .word_in(in_data), .word_out(word_new)
  );

  // per-packet fields sampled with the start word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q   <= 1'b0;
      ver_bad_q <= 1'b0;
      len_bad_q <= 1'b0;
      over_q    <= 1'b0;
      ttl_q     <= '0;
    end else begin
      if (sop) begin
        local_q   <= local_dst;
        ver_bad_q <= (in_data[31:28] != IPV4_VERSION);
        len_bad_q <= (in_data[27:24] < MIN_HDR_WORDS);
        over_q    <= (in_data[15:0] > mtu);
      end
      if (hdr_fire && is_ttl_word) ttl_q <= in_data[31:24];
    end
  end

  assign ttl_fail = local_q ? (ttl_q == '0) : (ttl_q <= 8'd1);

  always_comb begin
    if (ver_bad_q)               rsn_next = RSN_VERSION;
    else if (len_bad_q)          rsn_next = RSN_HDRLEN;
    else if (sum_next != CKS_GOOD) rsn_next = RSN_CHECKSUM;
    else if (ttl_fail)           rsn_next = RSN_TTL;
    else                         rsn_next = RSN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      verdict_valid <= 1'b0;
      discard       <= 1'b0;
      drop_reason   <= '0;
      frag_needed   <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      verdict_valid <= verdict_fire;
      if (in_valid) out_data <= pass_word ? in_data : word_new;
      if (verdict_fire) begin
        drop_reason <= rsn_next;
        discard     <= (rsn_next != RSN_NONE);
        frag_needed <= !local_q && over_q;
      end
    end
  end
endmodule

// File: rtl/ipv4_fwd_checker_sva.sv
module ipv4_fwd_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        verdict_valid,
  input logic        discard,
  input logic [2:0]  drop_reason,
  input logic        frag_needed,
  input logic        pass_word,
  input logic        cur_local,
  input logic        local_q
);
  // R2
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2
  trailing_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_word |=> out_data == $past(in_data));

  // R6
  local_unmodified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_local) |=> out_data == $past(in_data));

  // R10
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);

  // R10
  verdict_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> out_valid);

  // R10
  discard_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (discard == (drop_reason != 3'd0)));

  // R11
  frag_not_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && frag_needed) |-> !local_q);
endmodule

bind ipv4_fwd_checker ipv4_fwd_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .verdict_valid(verdict_valid),
  .discard(discard), .drop_reason(drop_reason), .frag_needed(frag_needed),
  .pass_word(pass_word), .cur_local(cur_local), .local_q(local_q)
);

// File: tb/sim_ipv4_fwd_checker.sv
module sim_ipv4_fwd_checker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic [15:0] mtu = '0;
  logic        local_dst = 1'b0;
  logic        out_valid, verdict_valid, discard, frag_needed;
  logic [31:0] out_data;
  logic [2:0]  drop_reason;

  int checks = 0;
  int errors = 0;
  logic [31:0] hdr [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipv4_fwd_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .mtu(mtu), .local_dst(local_dst),
    .out_valid(out_valid), .out_data(out_data), .verdict_valid(verdict_valid),
    .discard(discard), .drop_reason(drop_reason), .frag_needed(frag_needed)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // end-around fold of a wide sum, written as a loop
  function automatic logic [15:0] fold16(input int unsigned s);
    int unsigned t = s;
    while ((t >> 16) != 0) t = (t & 32'hFFFF) + (t >> 16);
    return t[15:0];
  endfunction

  function automatic logic [15:0] patch_cks(input logic [15:0] c);
    return fold16(32'(c) + 32'h100);
  endfunction

  function automatic string rsn_tag(input int r, input bit loc);
    case (r)
      1: return "R3 reason";
      2: return "R4 reason";
      3: return "R5 reason";
      4: return loc ? "R6 reason" : "R8 reason";
      default: return "R10 accept";
    endcase
  endfunction

  task automatic idle_cycle();
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_data  = $urandom;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle out_valid", 32'(out_valid), 0);
    chk(verdict_valid == 1'b0, "R10 idle verdict", 32'(verdict_valid), 0);
  endtask

  task automatic send_packet(input logic [3:0] ver, input logic [3:0] ihl,
                             input logic [7:0] ttl, input bit loc,
                             input logic [15:0] totlen, input logic [15:0] mtu_v,
                             input bit bad_cks, input int tail, input string note);
    int eff;
    int unsigned s;
    int exp_rsn;
    bit exp_frag;
    logic [31:0] exp_w;
    eff = (ihl < 4'd5) ? 5 : int'(ihl);
    for (int i = 0; i < 16; i++) hdr[i] = $urandom;
    hdr[0] = {ver, ihl, 8'h00, totlen};
    hdr[2] = {ttl, hdr[2][23:16], 16'h0000};
    s = 0;
    for (int i = 0; i < eff; i++) s += 32'(hdr[i][31:16]) + 32'(hdr[i][15:0]);
    hdr[2][15:0] = ~fold16(s);
    if (bad_cks) hdr[2][15:0] = hdr[2][15:0] ^ 16'h0010;

    if (ver != 4'd4) exp_rsn = 1;
    else if (ihl < 4'd5) exp_rsn = 2;
    else if (bad_cks) exp_rsn = 3;
    else if (loc ? (ttl == 8'd0) : (ttl <= 8'd1)) exp_rsn = 4;
    else exp_rsn = 0;
    exp_frag = !loc && (totlen > mtu_v);

    mtu = mtu_v;
    local_dst = loc;
    for (int i = 0; i < eff + tail; i++) begin
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_data  = (i < eff) ? hdr[i] : $urandom;
      exp_w    = in_data;
      if (i == 2 && !loc) exp_w = {ttl - 8'd1, in_data[23:16], patch_cks(in_data[15:0])};
      @(negedge clk);
      chk(out_valid == 1'b1, "R2 out_valid", 32'(out_valid), 1);
      if (i == 2 && !loc)       chk(out_data == exp_w, "R7 rewritten word 2", out_data, exp_w);
      else if (loc && i < eff)  chk(out_data == exp_w, "R6 local word", out_data, exp_w);
      else                      chk(out_data == exp_w, "R2 word", out_data, exp_w);
      chk(verdict_valid == (i == eff - 1), "R10 verdict timing",
          32'(verdict_valid), 32'(i == eff - 1));
      if (i == eff - 1) begin
        chk(32'(drop_reason) == 32'(exp_rsn), {rsn_tag(exp_rsn, loc), " ", note},
            32'(drop_reason), 32'(exp_rsn));
        chk(discard == (exp_rsn != 0), "R10 discard", 32'(discard), 32'(exp_rsn != 0));
        chk(frag_needed == exp_frag, {"R11 frag ", note}, 32'(frag_needed), 32'(exp_frag));
      end
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired act=%h exp=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 0);
    chk(verdict_valid == 1'b0, "R1 verdict in reset", 32'(verdict_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && verdict_valid == 1'b0, "R1 after release",
        {30'b0, out_valid, verdict_valid}, 0);
    chk(discard == 1'b0 && frag_needed == 1'b0, "R1 flags after release",
        {30'b0, discard, frag_needed}, 0);

    // directed corner cases
    send_packet(4'd4, 4'd5, 8'd64, 1'b0, 16'd1500, 16'd1500, 1'b0, 0, "len equals mtu");
    send_packet(4'd4, 4'd5, 8'd64, 1'b0, 16'd1501, 16'd1500, 1'b0, 2, "len over mtu");
    // TTL expiry and oversize in one verdict
    send_packet(4'd4, 4'd5, 8'd1, 1'b0, 16'd1501, 16'd1500, 1'b0, 0, "ttl1 and oversize");
    send_packet(4'd4, 4'd5, 8'd0, 1'b0, 16'd40, 16'd1500, 1'b0, 0, "fwd ttl0");
    send_packet(4'd4, 4'd6, 8'd2, 1'b0, 16'd60, 16'd1500, 1'b0, 1, "fwd ttl2");
    send_packet(4'd4, 4'd5, 8'd0, 1'b1, 16'd40, 16'd1500, 1'b0, 0, "local ttl0");
    send_packet(4'd4, 4'd5, 8'd1, 1'b1, 16'd9000, 16'd1500, 1'b0, 1, "local ttl1 oversize");
    send_packet(4'd6, 4'd5, 8'd64, 1'b0, 16'd40, 16'd1500, 1'b0, 0, "version 6");
    send_packet(4'd4, 4'd3, 8'd64, 1'b0, 16'd40, 16'd1500, 1'b0, 1, "ihl 3");
    send_packet(4'd4, 4'd5, 8'd64, 1'b0, 16'd40, 16'd1500, 1'b1, 0, "bad checksum");
    // R9 priority: version beats length, checksum beats TTL
    send_packet(4'd5, 4'd2, 8'd64, 1'b0, 16'd40, 16'd1500, 1'b1, 0, "R9 ver over ihl");
    send_packet(4'd4, 4'd5, 8'd0, 1'b0, 16'd40, 16'd1500, 1'b1, 0, "R9 cks over ttl");
    send_packet(4'd4, 4'd15, 8'd255, 1'b0, 16'd60, 16'd59, 1'b0, 3, "ihl 15");
    idle_cycle();

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ver, ihl;
      logic [7:0] ttl;
      logic [15:0] tl, m;
      int pick;
      pick = $urandom_range(0, 19);
      ver  = (pick == 0) ? 4'($urandom_range(0, 15)) : 4'd4;
      ihl  = (pick == 1) ? 4'($urandom_range(0, 4)) : 4'($urandom_range(5, 15));
      pick = $urandom_range(0, 3);
      ttl  = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd1 : (pick == 2) ? 8'd2 : 8'($urandom);
      tl   = 16'($urandom_range(20, 9000));
      pick = $urandom_range(0, 2);
      m    = (pick == 0) ? tl : (pick == 1) ? tl - 16'd1 : 16'($urandom_range(576, 9000));
      send_packet(ver, ihl, ttl, ($urandom_range(0, 3) == 0), tl, m,
                  ($urandom_range(0, 9) == 0), $urandom_range(0, 3), "random");
      if ($urandom_range(0, 1) == 1) idle_cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule